// File: doc/BRIEF.md
# Random Center-Displacement PWM Generator

This block drives a single switch-control line at a fixed switching frequency. It does not compare against a triangle carrier. It works out the two switch instants of each period in closed form from a signed reference, which it samples once per period. Time inside a period is counted in timebase ticks, and each period is `4*R` ticks long. The count starts at the point where a virtual triangular carrier would have its negative peak. The output goes low at tick `R + u` and high again at tick `4R - (R + u)`, so the low pulse sits at the middle of the period.

With random mode selected, the whole low pulse moves by a pseudo-random offset. The offset is bounded by half of the high time of that period, so the pulse never crosses into the next period and the duty cycle is unchanged. A maximal-length LFSR supplies the randomness and steps once per period. Its state is folded into a uniform integer `n` in `[-NMAX, +NMAX]`, which scales the bound.

The reference, the mode and the random value are all taken at the period boundary, so a period already in progress is never changed. A one-clock strobe marks the first clock of every period. The defaults (`R = 250`, `CLK_DIV = 2`) give 25 kHz switching with 80 ns pulse-width resolution from a 50 MHz clock.

Top module: `rcd_pwm`

## Requirements
- R1: While `rst_n` is low, and after its release until the first period starts, `pwm_o` is 1 and `start_o` is 0.
- R2: A timebase tick occurs every `CLK_DIV` clocks, and the first tick after reset starts the first period. A period lasts exactly `4*R` ticks. `start_o` is 1 for exactly the first clock of each period and 0 otherwise.
- R3: In deterministic mode (`rand_en_i` = 0), `pwm_o` is 0 during period ticks `k` with `T1 <= k < T2`, where `T1 = R + u` and `T2 = 4R - T1`. At all other ticks it is 1, so `T1 + T2 = 4R`.
- R4: A reference outside `[-R, +R]` is saturated to the nearest limit before use.
- R5: `ref_i` and `rand_en_i` are sampled only on the clock that starts a period. Changes during a period have no effect on that period.
- R6: The LFSR is a right-shifting Galois register of `LFSR_W` bits with mask `TAPS` (default 16 bits, mask `0xB400`). Its state is loaded with `SEED` at reset. It advances once at every period start, in either mode, and the first period uses `SEED`. The random integer is `n = (state mod (2*NMAX+1)) - NMAX`.
- R7: In random mode, both edges move by `dT = (n * T1) / NMAX`, truncated toward zero, giving a low interval `T1 + dT <= k < T2 + dT`.
- R8: The edges in use always satisfy `0 <= T1 <= T2 <= 4R`, so the low pulse stays inside its own period.
- R9: At `u = +R` the output stays 1 for the whole period, and at `u = -R` it stays 0 for the whole period, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | REF_W | Signed reference u, sampled at period start |
| rand_en_i | input | 1 | 1 selects random center displacement, 0 selects a centred pulse |
| pwm_o | output | 1 | Switch control output, registered |
| start_o | output | 1 | One-clock strobe on the first clock of each period |

## Verification
The bench builds the block with `R = 10` and `CLK_DIV = 2`, so one period is 40 ticks or 80 clocks. At this size every reference value from `-R-3` to `R+3` can be swept in both modes in a short run. The sweep covers both saturation limits, the all-high and all-low endpoints, and the region where the random shift spans the whole high time. Each period is checked at every clock against edges the bench computes from the reference, the LFSR arithmetic and the truncating shift formula. A reference change made during every period shows that a waveform already in progress is left unchanged.

// File: rtl/rcd_pwm_pkg.sv
// Package: shared arithmetic helpers for the random center-displacement PWM.
// Assumes: all quantities fit comfortably in a 32-bit signed int.
package rcd_pwm_pkg;

    // Saturate a signed value into [-lim, +lim].
    function automatic int rcd_clamp(input int v, input int lim);
        if (v > lim)
            return lim;
        else if (v < -lim)
            return -lim;
        return v;
    endfunction

    // Scaled random shift, truncated toward zero (SV int division).
    function automatic int rcd_shift(input int n, input int span, input int nmax);
        return (n * span) / nmax;
    endfunction

endpackage

// File: rtl/rcd_tick_gen.sv
// Module: rcd_tick_gen
// Produces a one-clock timebase enable every DIV clocks.
// Assumes: DIV >= 1; with DIV == 1 the enable is held high.
module rcd_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (DIV == 1) begin : g_pass
            // Purpose: every clock is a timebase tick.
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] div_q;

            // Purpose: free-running divide counter.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    div_q <= '0;
                else if (div_q == LAST)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign tick_o = (div_q == LAST);

            // R2: ticks are never on consecutive clocks when dividing
            a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/rcd_lfsr.sv
// Module: rcd_lfsr
// Galois LFSR stepped once per period, folded into a uniform integer
// in [-NMAX, +NMAX] by modulo reduction.
// Assumes: TAPS is a maximal-length mask for width W, SEED is nonzero.
module rcd_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter int          NMAX = 100,
    localparam int         NW   = $clog2(NMAX + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv_i,
    output logic signed [NW-1:0] n_o
);

    logic [W-1:0] state_q;

    // Purpose: advance the register at each period start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (adv_i)
            state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
    end

    // Purpose: fold the state into the symmetric random range.
    always_comb begin
        int folded;
        folded = (int'(state_q) % (2 * NMAX + 1)) - NMAX;
        n_o    = NW'(folded);
    end

    // R6: register never locks up in the all-zero state
    a_r6_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R6: state moves only at a period start
    a_r6_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(state_q));

    // R6: folded value stays inside the symmetric range
    a_r6_n_range: assert property (@(posedge clk) disable iff (!rst_n)
        (n_o >= NW'(-NMAX)) && (n_o <= NW'(NMAX)));

endmodule

// File: rtl/rcd_edge_calc.sv
// Module: rcd_edge_calc
// Closed-form switch instants for one period: fall tick and rise tick of
// the low pulse, optionally displaced by a bounded random shift.
// Assumes: shift bound equals the first edge T1 (half the high time),
// which keeps both edges inside [0, 4R].
module rcd_edge_calc #(
    parameter int  R     = 250,
    parameter int  REF_W = 9,
    parameter int  NMAX  = 100,
    localparam int NW    = $clog2(NMAX + 1) + 1,
    localparam int CW    = $clog2(4 * R + 1)
) (
    input  logic signed [REF_W-1:0] ref_i,
    input  logic signed [NW-1:0]    n_i,
    input  logic                    rand_en_i,
    output logic        [CW-1:0]    fall_o,
    output logic        [CW-1:0]    rise_o
);
    import rcd_pwm_pkg::*;

    // Purpose: saturate the reference and form both displaced edges.
    always_comb begin
        int u_c;
        int base;
        int dt;
        u_c  = rcd_clamp(int'(ref_i), R);
        base = R + u_c;
        dt   = rand_en_i ? rcd_shift(int'(n_i), base, NMAX) : 0;
        fall_o = CW'(base + dt);
        rise_o = CW'(4 * R - base + dt);
    end

endmodule

// File: rtl/rcd_pwm.sv
// Module: rcd_pwm (top)
// Fixed-frequency PWM with symmetric regular sampling and optional random
// displacement of the low pulse. The period counter runs 0..4R-1 on
// timebase ticks; edges, mode and random value are latched at the boundary.
// Assumes: ref_i is signed two's complement; out-of-range values saturate.
module rcd_pwm #(
    parameter int           R       = 250,
    parameter int           CLK_DIV = 2,
    parameter int           REF_W   = 9,
    parameter int           NMAX    = 100,
    parameter int           LFSR_W  = 16,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic                    rand_en_i,
    output logic                    pwm_o,
    output logic                    start_o
);

    localparam int PER = 4 * R;
    localparam int CW  = $clog2(PER + 1);
    localparam int NW  = $clog2(NMAX + 1) + 1;
    localparam logic [CW-1:0] LAST = CW'(PER - 1);
    localparam logic [CW-1:0] MID  = CW'(2 * R);

    logic                 tick;
    logic                 boundary;
    logic signed [NW-1:0] n_rand;
    logic [CW-1:0]        fall_new, rise_new;

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] t1_q, t1_d;
    logic [CW-1:0] t2_q, t2_d;
    logic          mode_q, mode_d;
    logic          pwm_q, pwm_d;
    logic          start_q;

    rcd_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rcd_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED), .NMAX(NMAX)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (boundary),
        .n_o   (n_rand)
    );

    rcd_edge_calc #(.R(R), .REF_W(REF_W), .NMAX(NMAX)) u_edges (
        .ref_i     (ref_i),
        .n_i       (n_rand),
        .rand_en_i (rand_en_i),
        .fall_o    (fall_new),
        .rise_o    (rise_new)
    );

    assign boundary = tick && (cnt_q == LAST);

    // Purpose: next tick position, edges and output level.
    always_comb begin
        cnt_d  = cnt_q;
        t1_d   = t1_q;
        t2_d   = t2_q;
        mode_d = mode_q;
        if (tick)
            cnt_d = boundary ? '0 : cnt_q + 1'b1;
        if (boundary) begin
            t1_d   = fall_new;
            t2_d   = rise_new;
            mode_d = rand_en_i;
        end
        pwm_d = !((cnt_d >= t1_d) && (cnt_d < t2_d));
    end

    // Purpose: period state and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= LAST;
            t1_q    <= MID;
            t2_q    <= MID;
            mode_q  <= 1'b0;
            pwm_q   <= 1'b1;
            start_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            t1_q    <= t1_d;
            t2_q    <= t2_d;
            mode_q  <= mode_d;
            pwm_q   <= pwm_d;
            start_q <= boundary;
        end
    end

    assign pwm_o   = pwm_q;
    assign start_o = start_q;

    // R2: the strobe marks tick zero of a period
    a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (cnt_q == '0));

    // R5: edges held constant between period boundaries
    a_r5_edges_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(t1_q) && $stable(t2_q) && $stable(mode_q)));

    // R3: centred pulse is symmetric about mid-period
    a_r3_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (({1'b0, t1_q} + {1'b0, t2_q}) == (CW + 1)'(PER)));

    // R8: low pulse never leaves its own period
    a_r8_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_q <= t2_q) && (t2_q <= CW'(PER)));

endmodule

// File: tb/rcd_pwm_tb.sv
// Bench: sweeps every reference in [-R-3, R+3] in both modes, then a
// pseudo-random walk, checking each clock of each period against
// arithmetic expectations.
module rcd_pwm_tb;

    localparam int R       = 10;
    localparam int CLK_DIV = 2;
    localparam int REF_W   = 9;
    localparam int NMAX    = 100;
    localparam int PER     = 4 * R;
    localparam int SPAN    = 2 * R + 7;
    localparam int NPER    = 2 * SPAN + 40;
    localparam logic [15:0] TAPS = 16'hB400;
    localparam logic [15:0] SEED = 16'hACE1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic signed [REF_W-1:0] ref_i = '0;
    logic                    rand_en_i = 1'b0;
    logic                    pwm_o;
    logic                    start_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rcd_pwm #(.R(R), .CLK_DIV(CLK_DIV), .REF_W(REF_W), .NMAX(NMAX),
              .LFSR_W(16), .TAPS(TAPS), .SEED(SEED)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_i     (ref_i),
        .rand_en_i (rand_en_i),
        .pwm_o     (pwm_o),
        .start_o   (start_o)
    );

    function automatic int get_u(input int p);
        if (p < SPAN)
            return p - R - 3;
        else if (p < 2 * SPAN)
            return p - SPAN - R - 3;
        return ((p * 7) % (2 * R + 1)) - R;
    endfunction

    function automatic logic get_m(input int p);
        return (p >= SPAN);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = SEED;
        ref_i = REF_W'(get_u(0));
        rand_en_i = get_m(0);
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pwm in reset", int'(pwm_o), 1);
        check("R1 start in reset", int'(start_o), 0);
        rst_n = 1'b1;
        begin
            int guard;
            guard = 0;
            @(negedge clk);
            while (!start_o && guard < 10) begin
                check("R1 pwm before first period", int'(pwm_o), 1);
                guard++;
                @(negedge clk);
            end
        end
        for (int p = 0; p < NPER; p++) begin
            int cu, uc, base, n, dt, t1e, t2e, bad, first_i, first_a, first_e, start_bad;
            logic cm;
            string tag;
            cu = get_u(p);
            cm = get_m(p);
            uc = (cu > R) ? R : ((cu < -R) ? -R : cu);
            base = R + uc;
            // R6: random integer from the current LFSR state
            n = (int'(lfsr) % (2 * NMAX + 1)) - NMAX;
            dt = cm ? (n * base) / NMAX : 0;
            t1e = base + dt;
            t2e = PER - base + dt;
            if (uc == R || uc == -R)
                tag = (cu != uc) ? "R4" : "R9";
            else
                tag = cm ? "R7/R8/R6" : "R3";
            // R5: change the inputs while this period runs
            ref_i = REF_W'(get_u(p + 1));
            rand_en_i = get_m(p + 1);
            bad = 0;
            start_bad = 0;
            first_i = -1;
            first_a = 0;
            first_e = 0;
            for (int i = 0; i < PER * CLK_DIV; i++) begin
                int k;
                int e;
                k = i / CLK_DIV;
                e = ((k >= t1e) && (k < t2e)) ? 0 : 1;
                if (int'(pwm_o) != e) begin
                    if (first_i < 0) begin
                        first_i = i;
                        first_a = int'(pwm_o);
                        first_e = e;
                    end
                    bad++;
                end
                if (int'(start_o) != ((i == 0) ? 1 : 0))
                    start_bad++;
                @(negedge clk);
            end
            checks++;
            if (bad != 0) begin
                errors++;
                $display("FAIL %s/R5 period %0d u=%0d rnd=%0d clk %0d: actual=%0d expected=%0d",
                         tag, p, cu, cm, first_i, first_a, first_e);
            end
            check("R2 start strobe count", start_bad, 0);
            check("R2 next period start", int'(start_o), 1);
            lfsr = (lfsr >> 1) ^ (lfsr[0] ? TAPS : 16'h0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule